// File: doc/BRIEF.md
# Linear Delta Bitstream Reconstructor

This block turns a one-bit-per-sample delta stream back into a multi-bit staircase waveform. It holds a running estimate. Each accepted stream bit moves that estimate up or down by a fixed step. The updated estimate is presented as a reconstructed sample. The arithmetic matches a delta encoder that uses the same start value, the same step and the same clamping, so a paired encoder and decoder hold identical estimates.

Over a long stream, bit errors or lost bits can make the decoder's estimate drift away from the encoder's. A full-resolution reference word can be loaded at any time to correct this. The loaded word replaces the estimate and is also presented as a sample.

Top module: `dm_recon_top`

## Requirements
- R1: After synchronous reset the estimate is 2048 (midscale of a 12-bit range), and `smp_vld` is low.
- R2: An accepted stream bit of 1 raises the estimate by the step (default 32).
- R3: A rise that would pass 4095 saturates at 4095.
- R4: An accepted stream bit of 0 lowers the estimate by the step. If the estimate is below the step, the result is clamped to 0.
- R5: Each accepted bit (`bit_vld` high) produces exactly one output sample. `smp_vld` is high in the cycle after `bit_vld`, and `smp_val` holds the updated estimate.
- R6: When `ref_ld` is high, `ref_val` replaces the estimate. A sample carrying that value is presented one cycle later.
- R7: If `ref_ld` and `bit_vld` are both high in the same cycle, the reference load wins and the stream bit has no effect.
- R8: In a cycle with neither `bit_vld` nor `ref_ld`, the estimate is unchanged and `smp_vld` is low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | A stream bit is offered this cycle |
| bit_dat | input | 1 | Stream bit: 1 = rise, 0 = fall |
| ref_ld | input | 1 | Load a reference word this cycle |
| ref_val | input | 12 | Reference word |
| smp_vld | output | 1 | Reconstructed sample is valid |
| smp_val | output | 12 | Reconstructed sample |

## Verification
The bench uses the default parameters: a 12-bit width, a step of 32 and a start value of 2048. With a step of 32, a run of about 64 equal bits drives the estimate from midscale into either rail. This brings both saturation edges into reach, along with the partial clamp below the step.

Reference loads place the estimate next to each rail, for example 4090 and 20, so that a single bit tests the clamping. The random stream mixes loads, idle cycles and bits that collide with loads.

// File: rtl/dm_recon_pkg.sv
package dm_recon_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_UP   = 2'd1,
    OP_DOWN = 2'd2,
    OP_LOAD = 2'd3
  } dm_op_e;
endpackage

// File: rtl/dm_recon_ctrl.sv
module dm_recon_ctrl
  import dm_recon_pkg::*;
(
  input  logic   bit_vld,
  input  logic   bit_dat,
  input  logic   ref_ld,
  output dm_op_e op
);
  always_comb begin
    if (ref_ld)       op = OP_LOAD;
    else if (bit_vld) op = bit_dat ? OP_UP : OP_DOWN;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/dm_recon_step.sv
module dm_recon_step
  import dm_recon_pkg::*;
#(
  parameter int W    = 12,
  parameter int STEP = 32
) (
  input  dm_op_e       op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] ref_val,
  output logic [W-1:0] nxt
);
  localparam logic [W:0]   STEP_X = (W+1)'(STEP);
  localparam logic [W-1:0] TOP    = {W{1'b1}};
  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, cur} + STEP_X;
    unique case (op)
      OP_LOAD: nxt = ref_val;
      OP_UP:   nxt = sum[W] ? TOP : sum[W-1:0];
      OP_DOWN: nxt = ({1'b0, cur} < STEP_X) ? '0 : cur - W'(STEP);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dm_recon_top.sv
module dm_recon_top
  import dm_recon_pkg::*;
#(
  parameter int W     = 12,
  parameter int STEP  = 32,
  parameter int START = 2048
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bit_vld,
  input  logic         bit_dat,
  input  logic         ref_ld,
  input  logic [W-1:0] ref_val,
  output logic         smp_vld,
  output logic [W-1:0] smp_val
);
  localparam logic [W-1:0] INIT = W'(START);
  localparam logic [W-1:0] TOP  = {W{1'b1}};

  dm_op_e       op;
  logic [W-1:0] acc_nxt;

  dm_recon_ctrl u_ctrl (
    .bit_vld(bit_vld), .bit_dat(bit_dat), .ref_ld(ref_ld), .op(op)
  );

  dm_recon_step #(.W(W), .STEP(STEP)) u_step (
    .op(op), .cur(smp_val), .ref_val(ref_val), .nxt(acc_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_val <= INIT;
      smp_vld <= 1'b0;
    end else begin
      smp_val <= acc_nxt;
      smp_vld <= bit_vld | ref_ld;
    end
  end

  assert_one_per_bit_R5: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> smp_vld);
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!bit_vld && !ref_ld) |=> (!smp_vld && $stable(smp_val)));
  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    ref_ld |=> (smp_val == $past(ref_val)));
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_dat && !ref_ld && smp_val > TOP - W'(STEP)) |=> (smp_val == TOP));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_dat && !ref_ld && smp_val < W'(STEP)) |=> (smp_val == '0));
  assert_rise_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_dat && !ref_ld) |=> (smp_val >= $past(smp_val)));
endmodule

// File: tb/test_dm_recon_top.sv
module test_dm_recon_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;
  localparam int STEP = 32;

  logic clk = 0, rst = 1;
  logic bit_vld = 0, bit_dat = 0, ref_ld = 0;
  logic [W-1:0] ref_val = '0;
  logic smp_vld;
  logic [W-1:0] smp_val;
  int checks = 0, errors = 0;
  int model = 2048;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dm_recon_top i_dm_recon_top (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_dat(bit_dat),
    .ref_ld(ref_ld), .ref_val(ref_val), .smp_vld(smp_vld), .smp_val(smp_val)
  );

  function automatic int model_next(int cur, bit v, bit d, bit l, int r);
    if (l) return r;
    if (!v) return cur;
    if (d) return (cur + STEP > 4095) ? 4095 : cur + STEP;
    return (cur < STEP) ? 0 : cur - STEP;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one cycle, sample after the edge
  task automatic cyc(bit v, bit d, bit l, int r, string req);
    bit_vld = v; bit_dat = d; ref_ld = l; ref_val = W'(r);
    model = model_next(model, v, d, l, r);
    @(posedge clk); #1;
    check({req, " val"}, smp_val, model);
    check({req, " vld"}, smp_vld, v | l);
    bit_vld = 0; ref_ld = 0;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst = 0; #1;
    check("R1 reset val", smp_val, 2048);
    check("R1 reset vld", smp_vld, 0);
    cyc(1, 1, 0, 0, "R2 up");
    cyc(1, 0, 0, 0, "R4 down");
    cyc(0, 0, 0, 0, "R8 idle");
    cyc(0, 0, 1, 4090, "R6 load");
    cyc(1, 1, 0, 0, "R3 saturate");
    cyc(1, 1, 0, 0, "R3 stay top");
    cyc(0, 0, 1, 20, "R6 load low");
    cyc(1, 0, 0, 0, "R4 clamp");
    cyc(1, 0, 0, 0, "R4 stay zero");
    cyc(0, 0, 1, 32, "R6 load step");
    cyc(1, 0, 0, 0, "R4 exact step");
    cyc(1, 1, 1, 1000, "R7 load wins");
    cyc(1, 0, 1, 7, "R7 load wins down");
    for (int i = 0; i < 70; i++) cyc(1, 1, 0, 0, "R3 run up");
    for (int i = 0; i < 70; i++) cyc(1, 0, 0, 0, "R4 run down");
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 15);
      cyc(k < 11, $urandom_range(0, 1), k == 15 || k == 0,
          $urandom_range(0, 4095), "R5 random");
    end
    rst = 1; @(posedge clk); #1; rst = 0; model = 2048;
    check("R1 re-reset", smp_val, 2048);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule